// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It drives a trial code to an external DAC, reads back a single comparator decision each clock, and settles one result bit per clock from the most significant bit down to the least significant. A sample/hold control stays high for the whole search. When the search ends, the block loads the result register and raises end-of-conversion in the same clock. The decisions also leave the block as a serial stream, most significant bit first.

A conversion is armed by the rising edge of the start input and launched by its falling edge. A new rising edge during a search abandons it and re-arms the block. If end-of-conversion is wired straight back to start, the block converts continuously. After reset one external start pulse is needed to begin this loop. A separate address strobe captures a 3-bit channel number on its rising edge. That number selects the analog source for the external multiplexer.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, eoc_o, hold_o, serial_valid_o, dac_code_o, result_o and chan_sel_o are all zero.
- R2: In the first cycle of a conversion, hold_o is 1 and dac_code_o holds only its most significant bit (0x80 for 8 bits).
- R3: Each tested bit stays 1 when cmp_above_i is 1 while that trial code is driven, and is cleared otherwise. The next lower bit is then set to 1. The final result is therefore the largest code whose DAC level the input exceeds.
- R4: Exactly RES_W decisions are made. Count the clock edge that first samples start_i low after it was high as edge 1. eoc_o is high after edge RES_W+1, and result_o holds the new value in that same cycle.
- R5: One clock edge after start_i is sampled rising, eoc_o and hold_o are 0. No search runs while start_i stays high.
- R6: A rising start_i during a search ends the search on the next edge: hold_o goes to 0, dac_code_o returns to 0 and eoc_o stays 0. The following falling edge begins a fresh, complete conversion.
- R7: When eoc_o is tied to start_i, conversions repeat without external action, and eoc_o rises once every RES_W+2 cycles.
- R8: chan_sel_o takes the value of chan_addr_i one edge after addr_strobe_i is sampled rising. Changes on chan_addr_i at any other time are ignored.
- R9: result_o changes only in the cycle in which eoc_o rises. An abandoned search leaves result_o unchanged.
- R10: hold_o is high for exactly RES_W cycles per completed conversion and is never high together with eoc_o.
- R11: serial_valid_o pulses once per decision, one edge after that decision. serial_bit_o carries the decided bits most significant first, and they equal the bits of result_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Rising edge arms, falling edge launches a conversion |
| cmp_above_i | input | 1 | Comparator: 1 when the held input exceeds the DAC level |
| addr_strobe_i | input | 1 | Rising edge captures chan_addr_i |
| chan_addr_i | input | CHAN_W (3) | Channel number to capture |
| dac_code_o | output | RES_W (8) | Trial code to the DAC |
| hold_o | output | 1 | Sample/hold control, 1 = hold |
| chan_sel_o | output | CHAN_W (3) | Latched channel select |
| eoc_o | output | 1 | End of conversion, 1 = result valid |
| result_o | output | RES_W (8) | Last completed result |
| serial_bit_o | output | 1 | Most recent decided bit |
| serial_valid_o | output | 1 | serial_bit_o carries a new decision |

## Verification
A wrong bit index or a bad trial update inside the search changes dac_code_o in the very next cycle. It also ends in a wrong result_o and serial stream, which the scoreboard compares at each rising eoc_o. A state machine that misses an arm or abort event shows up within one clock as eoc_o or hold_o failing to drop. A miscounted search length moves the eoc_o edge away from cycle RES_W+1. A channel latch that follows the address bus directly changes chan_sel_o in a cycle with no strobe edge. The bench drives several channels with distinct analog levels, so it shows this both as a port mismatch and as a wrong converted value.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
// Shared types for the successive-approximation controller.
package sar_pkg;

    // Sequencer phases: idle, armed (start high), searching.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CONV  = 2'd2
    } sar_state_t;

endpackage

// File: rtl/sar_edge_det.sv
`timescale 1ns/1ps
// Edge detector for a synchronous control input.
// Assumes the input is already in the clk domain. It reports the rising
// and falling edge in the cycle the new level is first sampled.
module sar_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic level_q;

    // Remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;
    assign fall_o = ~level_i & level_q;
endmodule

// File: rtl/sar_chan_latch.sv
`timescale 1ns/1ps
// Channel select latch.
// Captures the channel address on the rising edge of the strobe and holds it
// until the next rising edge. Assumes the strobe and address are synchronous.
module sar_chan_latch #(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [CHAN_W-1:0] addr_i,
    output logic [CHAN_W-1:0] sel_o
);
    logic strobe_q;

    // Track the strobe so that only its rising edge loads the select.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    // Load the select on a strobe rising edge, keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sel_o <= '0;
        else if (strobe_i && !strobe_q)  sel_o <= addr_i;
    end
endmodule

// File: rtl/sar_search.sv
`timescale 1ns/1ps
// Binary-search engine.
// On go_i it loads a midscale trial and then settles one bit per clock from
// the MSB down, using the comparator decision for the bit under test.
// clr_i abandons a search and zeroes the trial. The result register is
// written only when the LSB decision is made. Assumes clr_i and go_i are
// never high together.
module sar_search #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             go_i,
    input  logic             cmp_above_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] result_o,
    output logic             busy_o,
    output logic             last_o,
    output logic             ser_bit_o,
    output logic             ser_vld_o
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);
    localparam logic [RES_W-1:0] MID_CODE = RES_W'(1) << (RES_W - 1);

    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] next_trial;

    // Next trial: resolve the bit under test, then raise the bit below it.
    always_comb begin
        next_trial = trial_o;
        for (int b = 0; b < RES_W; b++) begin
            if (b == int'(idx_q) && !cmp_above_i) next_trial[b] = 1'b0;
            if (b + 1 == int'(idx_q))             next_trial[b] = 1'b1;
        end
    end

    assign last_o = busy_o && (idx_q == '0);

    // Search state: trial code, bit index and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_o <= '0;
            idx_q   <= '0;
            busy_o  <= 1'b0;
        end else if (clr_i) begin
            trial_o <= '0;
            idx_q   <= '0;
            busy_o  <= 1'b0;
        end else if (go_i) begin
            trial_o <= MID_CODE;
            idx_q   <= TOP_IDX;
            busy_o  <= 1'b1;
        end else if (busy_o) begin
            trial_o <= next_trial;
            if (idx_q == '0) busy_o <= 1'b0;
            else             idx_q  <= idx_q - 1'b1;
        end
    end

    // Result register: written only by the final decision.
    always_ff @(posedge clk) begin
        if (!rst_n)                  result_o <= '0;
        else if (!clr_i && last_o)   result_o <= next_trial;
    end

    // Serial stream: one registered bit per decision, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_bit_o <= 1'b0;
            ser_vld_o <= 1'b0;
        end else begin
            ser_vld_o <= busy_o && !clr_i;
            if (busy_o && !clr_i) ser_bit_o <= cmp_above_i;
        end
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
// Successive-approximation conversion controller (top).
// Sequences arm on start rising, launch on start falling, and abort on a
// new start rising during a search. It raises end-of-conversion when the
// last bit is settled. Holds the sample for the whole search. Assumes all
// inputs are synchronous to clk and the comparator settles within a cycle.
module sar_conv_ctrl #(
    parameter int RES_W  = 8,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_above_i,
    input  logic              addr_strobe_i,
    input  logic [CHAN_W-1:0] chan_addr_i,
    output logic [RES_W-1:0]  dac_code_o,
    output logic              hold_o,
    output logic [CHAN_W-1:0] chan_sel_o,
    output logic              eoc_o,
    output logic [RES_W-1:0]  result_o,
    output logic              serial_bit_o,
    output logic              serial_valid_o
);
    import sar_pkg::*;

    sar_state_t state_q;
    logic start_rise, start_fall, launch, last_step;

    sar_edge_det start_edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (start_i),
        .rise_o  (start_rise),
        .fall_o  (start_fall)
    );

    sar_chan_latch #(.CHAN_W(CHAN_W)) chan_latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (addr_strobe_i),
        .addr_i   (chan_addr_i),
        .sel_o    (chan_sel_o)
    );

    assign launch = (state_q == ST_ARMED) && start_fall;

    sar_search #(.RES_W(RES_W)) search_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (start_rise),
        .go_i        (launch),
        .cmp_above_i (cmp_above_i),
        .trial_o     (dac_code_o),
        .result_o    (result_o),
        .busy_o      (hold_o),
        .last_o      (last_step),
        .ser_bit_o   (serial_bit_o),
        .ser_vld_o   (serial_valid_o)
    );

    // Phase sequencing and end-of-conversion flag; a start rise wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            eoc_o   <= 1'b0;
        end else if (start_rise) begin
            state_q <= ST_ARMED;
            eoc_o   <= 1'b0;
        end else begin
            case (state_q)
                ST_ARMED: if (start_fall) state_q <= ST_CONV;
                ST_CONV: if (last_step) begin
                    state_q <= ST_IDLE;
                    eoc_o   <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for sar_conv_ctrl, attached by bind.
module sar_conv_ctrl_chk #(
    parameter int RES_W  = 8,
    parameter int CHAN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              addr_strobe_i,
    input logic [RES_W-1:0]  dac_code_o,
    input logic              hold_o,
    input logic [CHAN_W-1:0] chan_sel_o,
    input logic              eoc_o,
    input logic [RES_W-1:0]  result_o,
    input logic              serial_valid_o
);
    localparam int CW = $clog2(RES_W + 1) + 1;
    localparam logic [RES_W-1:0] MID_CODE = RES_W'(1) << (RES_W - 1);

    logic [CW-1:0] hold_cnt;

    // Length of the current hold window in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_cnt <= '0;
        else if (hold_o) hold_cnt <= hold_cnt + 1'b1;
        else             hold_cnt <= '0;
    end

    // R2
    midscale_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> dac_code_o == MID_CODE);

    // R4
    decision_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_o) |-> hold_cnt == CW'(RES_W));

    // R5
    arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_i) && !$past(start_i, 2)) |-> (!eoc_o && !hold_o));

    // R8
    chan_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel_o != $past(chan_sel_o)) |-> $past(addr_strobe_i));

    // R9
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(eoc_o) |-> $stable(result_o));

    // R10
    hold_eoc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_o && eoc_o));

    // R11
    serial_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serial_valid_o |-> $past(hold_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W), .CHAN_W(CHAN_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .addr_strobe_i  (addr_strobe_i),
    .dac_code_o     (dac_code_o),
    .hold_o         (hold_o),
    .chan_sel_o     (chan_sel_o),
    .eoc_o          (eoc_o),
    .result_o       (result_o),
    .serial_valid_o (serial_valid_o)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;
    localparam int RES_W  = 8;
    localparam int CHAN_W = 3;
    localparam int AW     = RES_W + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_drv = 1'b0;
    logic free_run = 1'b0;
    logic addr_strobe = 1'b0;
    logic [CHAN_W-1:0] chan_addr = '0;
    logic [AW-1:0] ana [0:7];

    logic start_w, cmp_w;
    logic [RES_W-1:0] dac_code, result;
    logic hold, eoc, ser_bit, ser_vld;
    logic [CHAN_W-1:0] chan_sel;

    int checks = 0;
    int fails = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    assign start_w = free_run ? eoc : start_drv;
    assign cmp_w   = ana[chan_sel] > {dac_code, 4'h0};

    sar_conv_ctrl #(.RES_W(RES_W), .CHAN_W(CHAN_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_w),
        .cmp_above_i    (cmp_w),
        .addr_strobe_i  (addr_strobe),
        .chan_addr_i    (chan_addr),
        .dac_code_o     (dac_code),
        .hold_o         (hold),
        .chan_sel_o     (chan_sel),
        .eoc_o          (eoc),
        .result_o       (result),
        .serial_bit_o   (ser_bit),
        .serial_valid_o (ser_vld)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Largest code c with c*16 below the analog level.
    function automatic int exp_code(input int a);
        int c;
        if (a == 0) return 0;
        c = (a - 1) >> 4;
        return (c > 255) ? 255 : c;
    endfunction

    // Monitor: pops expected results at each eoc rising edge.
    logic hold_d = 1'b0, eoc_d = 1'b0;
    int sh = 0, sn = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold && !hold_d) begin sh = 0; sn = 0; end
            if (ser_vld) begin sh = ((sh << 1) | int'(ser_bit)) & 255; sn++; end
            if (eoc && !eoc_d) begin
                if (exp_q.size() == 0) check(1'b0, "R3 unexpected eoc", int'(result), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(result) == e, "R3 result", int'(result), e);
                    check(sh == e && sn == RES_W, "R11 serial bits", sh, e);
                end
            end
            hold_d = hold;
            eoc_d  = eoc;
        end
    end

    task automatic set_chan(input int c);
        @(negedge clk);
        chan_addr   = CHAN_W'(c);
        addr_strobe = 1'b1;
        @(negedge clk);
        check(int'(chan_sel) == c, "R8 latch on strobe", int'(chan_sel), c);
        chan_addr = CHAN_W'(c + 3);
        @(negedge clk);
        check(int'(chan_sel) == c, "R8 address ignored while strobe high", int'(chan_sel), c);
        addr_strobe = 1'b0;
        @(negedge clk);
        chan_addr = CHAN_W'(c + 5);
        @(negedge clk);
        check(int'(chan_sel) == c, "R8 address ignored while strobe low", int'(chan_sel), c);
    endtask

    // Full conversion on the current channel with timing checks.
    task automatic convert();
        int n, hc;
        exp_q.push_back(exp_code(int'(ana[chan_sel])));
        @(negedge clk);
        start_drv = 1'b1;
        @(negedge clk);
        check(!eoc && !hold, "R5 arm clears eoc/hold", int'({eoc, hold}), 0);
        @(negedge clk);
        check(!hold, "R5 no search while start high", int'(hold), 0);
        start_drv = 1'b0;
        n = 0; hc = 0;
        while (!eoc && n < 50) begin
            @(negedge clk);
            n++;
            if (n == 1) check(hold && dac_code == 8'h80, "R2 midscale first", int'(dac_code), 128);
            if (hold) hc++;
        end
        check(n == RES_W + 1, "R4 eoc timing", n, RES_W + 1);
        check(hc == RES_W, "R10 hold length", hc, RES_W);
    endtask

    int r0, n0;
    int rise_t [3];

    initial begin
        #(5 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        ana[0] = 12'd2049; ana[1] = 12'd0;    ana[2] = 12'd4095; ana[3] = 12'd16;
        ana[4] = 12'd17;   ana[5] = 12'h555;  ana[6] = 12'hAAA;  ana[7] = 12'd2048;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!eoc && !hold && !ser_vld && dac_code == 0 && result == 0 && chan_sel == 0,
              "R1 reset state", int'({eoc, hold, ser_vld}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!eoc && result == 0, "R1 state after release", int'(result), 0);

        // R3 over several levels and channels
        for (int c = 0; c < 8; c++) begin
            set_chan(c);
            convert();
            check(eoc == 1'b1, "R4 eoc high at end", int'(eoc), 1);
        end

        // R6 abort mid-search; R9 result kept
        set_chan(5);
        exp_q.push_back(exp_code(int'(ana[5])));
        @(negedge clk); start_drv = 1'b1;
        @(negedge clk); start_drv = 1'b0;
        repeat (4) @(negedge clk);
        check(hold, "R6 search running", int'(hold), 1);
        r0 = int'(result);
        start_drv = 1'b1;
        @(negedge clk);
        check(!hold && !eoc && dac_code == 0, "R6 abort clears", int'({hold, eoc}), 0);
        check(int'(result) == r0, "R9 result kept on abort", int'(result), r0);
        start_drv = 1'b0;
        n0 = 0;
        while (!eoc && n0 < 50) begin @(negedge clk); n0++; end
        check(n0 == RES_W + 1, "R6 restart completes", n0, RES_W + 1);

        // R7 free-running with eoc tied to start
        set_chan(6);
        for (int k = 0; k < 3; k++) exp_q.push_back(exp_code(int'(ana[6])));
        @(negedge clk);
        free_run = 1'b1;
        begin
            int t, got;
            logic pe;
            t = 0; got = 0; pe = eoc;
            while (got < 3 && t < 200) begin
                @(negedge clk);
                t++;
                if (eoc && !pe) begin rise_t[got] = t; got++; end
                pe = eoc;
            end
            start_drv = 1'b1;
            free_run  = 1'b0;
            check(got == 3, "R7 three conversions", got, 3);
            check(rise_t[1] - rise_t[0] == RES_W + 2, "R7 period", rise_t[1] - rise_t[0], RES_W + 2);
            check(rise_t[2] - rise_t[1] == RES_W + 2, "R7 period", rise_t[2] - rise_t[1], RES_W + 2);
        end
        repeat (20) @(negedge clk);
        check(!hold, "R5 held start stays armed", int'(hold), 0);
        check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule